// File: doc/BRIEF.md
# Programmable Square-Wave Output and Oscillator Status Control

This block owns the control/status byte of a real-time clock and the clock output pin that hangs off it. A binary prescaler runs from the oscillator-rate clock. It gives four output rates and the once-per-second tick that advances the timekeeping counters. When the wave is switched off, the output pin is parked at a level that the host programs. A sticky flag records that the oscillator has stopped at some time, so software can judge whether the time it reads is trustworthy. The host may only clear this flag.

The clock input `clk` samples at twice the nominal oscillator rate, so the fastest output rate is a toggling prescaler bit. With the default `DIV_W` of 16, the slowest tap has a period of 65536 cycles, which is one second. The oscillator-stopped condition is an input, because the analog detector sits outside this block. The host port is a plain register port with no handshake. A write takes effect at the next clock edge, and the read value is always presented from the current register state. No data stream passes through the block, so no port here uses valid/ready.

Top module: `sqw_osc_ctrl`

## Requirements
- R1: After reset, `rd_data` reads 0xB3 (level 1, stop flag 1, wave enabled, rate 11) and `sec_tick` is 0.
- R2: `rd_data` bit 7 is the static level, bit 5 the stop flag, bit 4 the wave enable and bits 1:0 the rate. Bits 6, 3 and 2 always read 0, whatever was written.
- R3: With the wave enabled, the rate code chooses the output period in running cycles: 11 gives 2, 10 gives 8, 01 gives 16 and 00 gives 2^DIV_W. The output is prescaler bit 0, 2, 3 or DIV_W-1 in turn.
- R4: With the wave disabled (bit 4 = 0), `sqw_level` equals bit 7 of the control byte.
- R5: `sec_tick` is a one-cycle pulse once every 2^DIV_W running cycles. It is high in the cycle in which the slowest tap falls from 1 to 0, whether or not the wave is enabled.
- R6: The cycle after `osc_stopped` or `osc_disable` is seen high at a clock edge, the stop flag reads 1.
- R7: A write with bit 5 = 0 clears the stop flag. A write with bit 5 = 1 leaves it unchanged. A stop condition in the same cycle as a clearing write wins, and the flag stays 1.
- R8: While `osc_stopped` or `osc_disable` is high, the prescaler holds its value. `sec_tick` stays 0 and the selected tap does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock (two samples per nominal oscillator period) |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_stopped | input | 1 | High while the oscillator detector reports no oscillation |
| osc_disable | input | 1 | Oscillator-disable bit from the seconds register |
| wr_en | input | 1 | Host write strobe for the control byte |
| wr_data | input | 8 | Host write data |
| rd_data | output | 8 | Current control/status byte |
| sqw_level | output | 1 | Level for the open-drain output pin (1 = released) |
| sec_tick | output | 1 | One-second pulse to the time counter chain |

## Verification
The bench builds the block with a 6-bit prescaler. It then sweeps every combination of static level, wave enable and rate code, and compares the output and the tick on every cycle against an arithmetic model. If a tap were chosen wrongly, the period would be off. If the static fallback were broken, the pin would toggle while disabled. If the tick were tied to the output enable, seconds would be lost whenever the wave is off. The stop-flag cases cover a write of 1 to the flag, a clear that meets a stop in the same cycle, and prescaler hold while stopped or disabled. A design with those wrong would lose the flag, set it from software, or keep counting time with no oscillator.

// File: rtl/sqw_pkg.sv
package sqw_pkg;

  typedef enum logic [1:0] {
    RATE_SLOW = 2'b00,
    RATE_4K   = 2'b01,
    RATE_8K   = 2'b10,
    RATE_32K  = 2'b11
  } rate_e;

  typedef struct packed {
    logic  static_lvl;
    logic  stop_flag;
    logic  wave_en;
    rate_e rate;
  } ctrl_t;

  localparam int BIT_LVL  = 7;
  localparam int BIT_FLAG = 5;
  localparam int BIT_EN   = 4;

  localparam ctrl_t CTRL_RESET = '{static_lvl: 1'b1, stop_flag: 1'b1,
                                   wave_en: 1'b1, rate: RATE_32K};

  function automatic logic [7:0] pack_ctrl(input ctrl_t c);
    logic [7:0] v;
    v           = '0;
    v[BIT_LVL]  = c.static_lvl;
    v[BIT_FLAG] = c.stop_flag;
    v[BIT_EN]   = c.wave_en;
    v[1:0]      = c.rate;
    return v;
  endfunction

endpackage

// File: rtl/sqw_divider.sv
module sqw_divider #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  output logic [DIV_W-1:0] count,
  output logic             tick
);
  localparam logic [DIV_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      tick  <= 1'b0;
    end else begin
      tick <= run && (count == CNT_MAX);
      if (run) count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/sqw_ctrl_reg.sv
module sqw_ctrl_reg
  import sqw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       stop_seen,
  output ctrl_t      ctrl
);
  logic unused_wr_bits;
  assign unused_wr_bits = ^{wr_data[6], wr_data[3:2]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= CTRL_RESET;
    end else begin
      if (wr_en) begin
        ctrl.static_lvl <= wr_data[BIT_LVL];
        ctrl.wave_en    <= wr_data[BIT_EN];
        ctrl.rate       <= rate_e'(wr_data[1:0]);
      end
      if (stop_seen)
        ctrl.stop_flag <= 1'b1;
      else if (wr_en && !wr_data[BIT_FLAG])
        ctrl.stop_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/sqw_wave_sel.sv
module sqw_wave_sel
  import sqw_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic [DIV_W-1:0] count,
  input  logic             wave_en,
  input  logic             static_lvl,
  input  rate_e            rate,
  output logic             level
);
  localparam int NUM_RATES = 4;
  localparam int TAP_IDX [NUM_RATES] = '{DIV_W-1, 3, 2, 0};

  logic [NUM_RATES-1:0] taps;
  logic                 unused_cnt;
  assign unused_cnt = ^count;

  for (genvar i = 0; i < NUM_RATES; i++) begin : g_tap
    assign taps[i] = count[TAP_IDX[i]];
  end

  always_comb begin
    if (wave_en) level = taps[rate];
    else         level = static_lvl;
  end
endmodule

// File: rtl/sqw_osc_ctrl.sv
module sqw_osc_ctrl
  import sqw_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_stopped,
  input  logic       osc_disable,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       sqw_level,
  output logic       sec_tick
);
  ctrl_t            ctrl;
  logic [DIV_W-1:0] count;
  logic             stop_seen;

  assign stop_seen = osc_stopped | osc_disable;

  sqw_ctrl_reg u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .stop_seen(stop_seen), .ctrl(ctrl)
  );

  sqw_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(!stop_seen), .count(count), .tick(sec_tick)
  );

  sqw_wave_sel #(.DIV_W(DIV_W)) u_sel (
    .count(count), .wave_en(ctrl.wave_en), .static_lvl(ctrl.static_lvl),
    .rate(ctrl.rate), .level(sqw_level)
  );

  assign rd_data = pack_ctrl(ctrl);
endmodule

// File: rtl/sqw_osc_ctrl_chk.sv
module sqw_osc_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       osc_stopped,
  input logic       osc_disable,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       sqw_level,
  input logic       sec_tick
);
  assert_osf_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_stopped || osc_disable) |=> rd_data[5]);

  assert_osf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[5] && !(wr_en && !wr_data[5])) |=> rd_data[5]);

  assert_static_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[4] |-> (sqw_level == rd_data[7]));

  assert_tick_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> !sec_tick);

  assert_tick_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && $stable(rd_data[4:0]) && rd_data[4] && rd_data[1:0] == 2'b00)
      |-> $fell(sqw_level));

  assert_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_stopped || osc_disable) |=> !sec_tick);
endmodule

bind sqw_osc_ctrl sqw_osc_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .osc_stopped(osc_stopped), .osc_disable(osc_disable),
  .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
  .sqw_level(sqw_level), .sec_tick(sec_tick)
);

// File: tb/sqw_osc_ctrl_test.sv
`timescale 1ns/1ps
module sqw_osc_ctrl_test;
  localparam int DIV_W = 6;
  localparam int MAXC  = (1 << DIV_W) - 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_stopped = 1'b0;
  logic       osc_disable = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       sqw_level;
  logic       sec_tick;

  int n_checks = 0;
  int n_fail = 0;

  // bench shadow of the control byte
  logic       s_out = 1'b1, s_osf = 1'b1, s_en = 1'b1;
  logic [1:0] s_rate = 2'b11;

  // arithmetic model of the prescaler
  logic [DIV_W-1:0] m_cnt = '0;
  logic             m_tick = 1'b0;

  always #2.5 clk = ~clk;

  sqw_osc_ctrl #(.DIV_W(DIV_W)) uut (
    .clk(clk), .rst_n(rst_n), .osc_stopped(osc_stopped), .osc_disable(osc_disable),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .sqw_level(sqw_level), .sec_tick(sec_tick)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt  <= '0;
      m_tick <= 1'b0;
    end else begin
      m_tick <= !osc_stopped && !osc_disable && (int'(m_cnt) == MAXC);
      if (!osc_stopped && !osc_disable) m_cnt <= m_cnt + 1'b1;
    end
  end

  function automatic logic [7:0] exp_rd();
    return {s_out, 1'b0, s_osf, s_en, 2'b00, s_rate};
  endfunction

  function automatic logic exp_sqw();
    int tap;
    case (s_rate)
      2'b00: tap = DIV_W - 1;
      2'b01: tap = 3;
      2'b10: tap = 2;
      default: tap = 0;
    endcase
    return s_en ? m_cnt[tap] : s_out;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // called just after a negedge; returns just after a negedge
  task automatic do_write(input logic [7:0] d);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    s_out = d[7];
    s_en = d[4];
    s_rate = d[1:0];
    if (!d[5]) s_osf = 1'b0;
  endtask

  // compares output and tick with the model on each of n cycles
  task automatic sweep(input int n, input string req);
    int bad = 0;
    int last_act = 0;
    int last_exp = 0;
    for (int i = 0; i < n; i++) begin
      if (sqw_level !== exp_sqw() || sec_tick !== m_tick) begin
        bad++;
        last_act = {sqw_level, sec_tick};
        last_exp = {exp_sqw(), m_tick};
      end
      @(negedge clk);
    end
    check(bad == 0, req, last_act, last_exp);
  endtask

  initial begin
    #(200000 * 5);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(rd_data == 8'hB3, "R1 reset control byte", rd_data, 8'hB3);
    check(sec_tick == 1'b0, "R1 reset tick", sec_tick, 0);
    rst_n = 1'b1;
    @(negedge clk);
    sweep(70, "R3 default 32k rate after reset");

    do_write(8'h93);
    check(rd_data == 8'h93, "R7 write 0 clears flag", rd_data, 8'h93);
    do_write(8'hB3);
    check(rd_data == 8'h93, "R7 write 1 keeps flag clear", rd_data, 8'h93);
    do_write(8'hFF);
    check(rd_data == 8'h93, "R2 bits 6,3,2 read zero", rd_data, 8'h93);

    for (int o = 0; o < 2; o++) begin
      for (int e = 0; e < 2; e++) begin
        for (int r = 0; r < 4; r++) begin
          do_write({o[0], 1'b0, 1'b1, e[0], 2'b11, r[1:0]});
          check(rd_data == exp_rd(), "R2 field layout", rd_data, exp_rd());
          sweep(2 * (MAXC + 1) + 2, e ? "R3 R5 rate sweep" : "R4 R5 static level sweep");
        end
      end
    end

    do_write(8'h90);
    osc_stopped = 1'b1;
    @(negedge clk);
    s_osf = 1'b1;
    check(rd_data[5] == 1'b1, "R6 stop sets flag", rd_data[5], 1);
    sweep(20, "R8 held while stopped");
    osc_stopped = 1'b0;
    sweep(5, "R5 resumes after stop");

    do_write(8'h90);
    check(rd_data[5] == 1'b0, "R7 clear after stop", rd_data[5], 0);
    wr_en = 1'b1;
    wr_data = 8'h90;
    osc_disable = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    s_osf = 1'b1;
    check(rd_data[5] == 1'b1, "R7 stop beats clear", rd_data[5], 1);
    check(rd_data == 8'hB0, "R6 flag set by disable", rd_data, 8'hB0);
    sweep(2 * (MAXC + 1), "R8 held while disabled");
    osc_disable = 1'b0;
    sweep(3, "R8 resumes after disable");
    do_write(8'h80);
    check(rd_data == 8'h80, "R7 clear after disable", rd_data, 8'h80);
    sweep(3 * (MAXC + 1), "R5 tick with wave disabled");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule